// File: doc/BRIEF.md
# Half-Duplex Serial Master with Start Bit

This block is a master-only synchronous serial engine that owns a serial clock line and one shared data line. Each transfer goes one way only, picked by a direction input sampled when the transfer begins. Transmit words go out MSB first and are framed by a low start bit and a high stop bit. Receive words are simply clocked in, and the data line is left released for the peripheral to drive.

Software sets up an 8-bit mode register: interrupt enable, clock phase, clock polarity, word length, a 2-bit rate select and two spare bits that are stored but not used. A write to the data register starts a transfer. That register rotates on transmit and shifts on receive, so a short 6-bit word moves from the high bits into the low bits. A completion flag and a maskable interrupt report the end of a transfer. The flag stays set until a status read clears it, and until then no new transfer can start.

Top module: `hsm_master`

## Requirements
- R1: After reset the mode register and the data register are 0, `busy`, `done` and `irq` are 0, `sclk` is 0 and `sd_oe` is 0.
- R2: On a transmit, the block drives `sd_o` low with `sd_oe`=1 for exactly 2H system clocks, with `sclk` at its idle level, before the first data bit.
- R3: On a receive (`dir_rx`=1 at the start), `sd_oe` stays 0 for the whole transfer and no start bit is sent.
- R4: Mode bit 4 selects the word length: 0 gives 8 bits and 1 gives 6 bits. Exactly that many sampling edges appear on `sclk`.
- R5: Transmit bits leave MSB first. The data register rotates left once per bit, so an 8-bit word comes back unchanged and a 6-bit word written to bits 7..2 ends up in bits 5..0.
- R6: Receive bits are sampled MSB first and shifted into bit 0. A 6-bit word ends up in bits 5..0, and bits 7..6 then hold the old bits 1..0.
- R7: Mode bits 3..2 (value B) set the half period H = 2^B system clocks. `done` rises (2N+4)·H clocks after the starting write edge for a transmit and 2N·H clocks after it for a receive, where N is the word length.
- R8: `sclk` rests at mode bit 5 (polarity) while no transfer is active. Mode bit 6 (phase) = 0 keeps the first half of each bit at the idle level, and = 1 puts the first half at the active level. Data changes at bit boundaries and is sampled at the mid-bit edge.
- R9: After the last transmit bit, `sd_o` is held high for 2H clocks, and then `sd_oe` drops.
- R10: `done` sets at the end of a transfer. `irq` equals `done` gated by mode bit 7 (interrupt enable).
- R11: A data write while `busy` is set (transfer active or `done` pending) is ignored. A `stat_rd` pulse clears `done` and `busy`, after which a write loads the register and starts a transfer.
- R12: Mode writes are accepted when no transfer is active and ignored during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode value: bit 7 irq enable, bit 6 phase, bit 5 polarity, bit 4 short word, bits 3..2 rate, bits 1..0 spare |
| data_we | input | 1 | Data register write strobe; starts a transfer |
| data_wdata | input | 8 | Data register write value |
| dir_rx | input | 1 | Transfer direction sampled at start: 0 transmit, 1 receive |
| stat_rd | input | 1 | Status read strobe; clears the completion flag |
| sd_i | input | 1 | Serial data line input |
| mode_q | output | 8 | Mode register contents |
| data_q | output | 8 | Data register contents |
| busy | output | 1 | Transfer active or completion pending |
| done | output | 1 | Completion flag |
| irq | output | 1 | Masked completion interrupt |
| sclk | output | 1 | Serial clock |
| sd_o | output | 1 | Serial data line output value |
| sd_oe | output | 1 | Serial data line output enable |

## Verification
The starting write is registered at one rising edge P0, so the line turns around right after P0. The start bit covers the 2H edges that follow, and `done` becomes visible right after edge P0 + (2N+4)·H for a transmit or P0 + 2N·H for a receive. The bench counts rising edges from P0 and samples every output on the falling edge in between, so each count of cycles, start-bit width, driven-line span and sampling edges is compared against a total computed from the mode value. Data register results are checked once `done` is seen, and the register's value right after a restart is checked on the falling edge after its write.

// File: rtl/hsm_pkg.sv
`timescale 1ns/1ps
// hsm_pkg: shared types for the half-duplex serial master.
// Assumes the mode register is 8 bits, laid out from bit 7 down as below.
package hsm_pkg;

    // Sequencer phase of a transfer.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_BITS  = 2'd2,
        PH_STOP  = 2'd3
    } hsm_phase_t;

    // Mode register, field order fixed by software decode (bit 7 first).
    typedef struct packed {
        logic       irq_en;
        logic       phase;
        logic       polarity;
        logic       short_word;
        logic [1:0] rate;
        logic [1:0] spare;
    } hsm_mode_t;

endpackage

// File: rtl/hsm_rate_div.sv
`timescale 1ns/1ps
// hsm_rate_div: half-period tick generator.
// Emits one tick every 2**rate_sel system clocks while run is high; the count
// restarts from zero whenever run is low, so the first tick comes a full half
// period after run rises. Assumes rate_sel is held stable while run is high.
module hsm_rate_div #(
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              tick
);
    localparam int HALF_MAX = 1 << ((1 << RATE_W) - 1);
    localparam int CNT_W    = $clog2(HALF_MAX) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Last count value of the current half period.
    always_comb begin
        limit = (CNT_W'(1) << rate_sel) - CNT_W'(1);
    end

    assign tick = run && (cnt == limit);

    // Advance the half-period counter, restarting on tick or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/hsm_shift_reg.sv
`timescale 1ns/1ps
// hsm_shift_reg: data register with parallel load, left rotate and left shift.
// Priority: load, then rotate (transmit bit done), then shift-in (receive sample).
// Assumes at most one of rot and shin is high in a cycle.
module hsm_shift_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         rot,
    input  logic         shin,
    input  logic         sin,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    // Per-bit next value: bit 0 takes the old MSB on rotate or the line on shift.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            always_comb begin
                if (load)      nxt[i] = load_val[i];
                else if (rot)  nxt[i] = q[W-1];
                else if (shin) nxt[i] = sin;
                else           nxt[i] = q[i];
            end
        end else begin : g_upper
            always_comb begin
                if (load)             nxt[i] = load_val[i];
                else if (rot || shin) nxt[i] = q[i-1];
                else                  nxt[i] = q[i];
            end
        end
    end

    // Register the next value.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/hsm_sequencer.sv
`timescale 1ns/1ps
// hsm_sequencer: transfer framing and line timing.
// Each bit period is two half periods, and every tick ends one half.
// Transmit: start (2 halves, line low, clock idle), N bits, stop (2 halves, line high).
// Receive: N bits only, line released. The completion flag sets on the final tick
// and clears on stat_rd. Assumes start only arrives while the flag is clear.
module hsm_sequencer
    import hsm_pkg::*;
#(
    parameter int W       = 8,
    parameter int SHORT_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rx_req,
    input  logic short_word,
    input  logic polarity,
    input  logic phase,
    input  logic tick,
    input  logic msb,
    input  logic stat_rd,
    output logic run,
    output logic rot,
    output logic shin,
    output logic sclk,
    output logic sd_o,
    output logic sd_oe,
    output logic done
);
    localparam int BCNT_W = $clog2(W);

    hsm_phase_t        ph;
    logic              half;
    logic              rx_q;
    logic [BCNT_W-1:0] bit_idx;
    logic [BCNT_W-1:0] last_idx;

    assign last_idx = short_word ? BCNT_W'(SHORT_W - 1) : BCNT_W'(W - 1);

    // Walk through the start, bit and stop phases and keep the completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= PH_IDLE;
            half    <= 1'b0;
            rx_q    <= 1'b0;
            bit_idx <= '0;
            done    <= 1'b0;
        end else begin
            if (stat_rd) done <= 1'b0;
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph      <= rx_req ? PH_BITS : PH_START;
                        rx_q    <= rx_req;
                        half    <= 1'b0;
                        bit_idx <= '0;
                    end
                end
                PH_START: begin
                    if (tick) begin
                        half <= ~half;
                        if (half) ph <= PH_BITS;
                    end
                end
                PH_BITS: begin
                    if (tick) begin
                        half <= ~half;
                        if (half) begin
                            if (bit_idx == last_idx) begin
                                if (rx_q) begin
                                    ph   <= PH_IDLE;
                                    done <= 1'b1;
                                end else begin
                                    ph <= PH_STOP;
                                end
                            end else begin
                                bit_idx <= bit_idx + BCNT_W'(1);
                            end
                        end
                    end
                end
                PH_STOP: begin
                    if (tick) begin
                        half <= ~half;
                        if (half) begin
                            ph   <= PH_IDLE;
                            done <= 1'b1;
                        end
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Register strobes: rotate at the end of a transmit bit, sample at mid-bit.
    assign run  = (ph != PH_IDLE);
    assign rot  = tick && (ph == PH_BITS) && half && !rx_q;
    assign shin = tick && (ph == PH_BITS) && !half && rx_q;

    // Serial clock: idle level outside bits; phase picks which half is active.
    always_comb begin
        if (ph == PH_BITS) sclk = polarity ^ (phase ? ~half : half);
        else               sclk = polarity;
    end

    // Data line: low start bit, data MSB, high stop bit; released on receive.
    always_comb begin
        sd_oe = run && !rx_q;
        case (ph)
            PH_BITS: sd_o = msb;
            PH_STOP: sd_o = 1'b1;
            default: sd_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/hsm_master.sv
`timescale 1ns/1ps
// hsm_master: half-duplex serial master top level.
// Holds the mode register, joins the rate divider, the data register and the
// sequencer, and derives busy and the masked interrupt. Mode writes are blocked
// while a transfer runs, so the sequencer can read the live mode fields.
module hsm_master
    import hsm_pkg::*;
#(
    parameter int W       = 8,
    parameter int SHORT_W = 6,
    parameter int RATE_W  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_we,
    input  logic [7:0]   mode_wdata,
    input  logic         data_we,
    input  logic [W-1:0] data_wdata,
    input  logic         dir_rx,
    input  logic         stat_rd,
    input  logic         sd_i,
    output logic [7:0]   mode_q,
    output logic [W-1:0] data_q,
    output logic         busy,
    output logic         done,
    output logic         irq,
    output logic         sclk,
    output logic         sd_o,
    output logic         sd_oe
);
    hsm_mode_t mode_r;
    logic      run;
    logic      tick;
    logic      rot;
    logic      shin;
    logic      start;

    assign start  = data_we && !busy;
    assign busy   = run || done;
    assign irq    = done && mode_r.irq_en;
    assign mode_q = mode_r;

    // Mode register: written only while no transfer is running.
    always_ff @(posedge clk) begin
        if (!rst_n)              mode_r <= '0;
        else if (mode_we && !run) mode_r <= hsm_mode_t'(mode_wdata);
    end

    hsm_rate_div #(.RATE_W(RATE_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .rate_sel (mode_r.rate[RATE_W-1:0]),
        .tick     (tick)
    );

    hsm_shift_reg #(.W(W)) u_sreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (data_wdata),
        .rot      (rot),
        .shin     (shin),
        .sin      (sd_i),
        .q        (data_q)
    );

    hsm_sequencer #(.W(W), .SHORT_W(SHORT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .rx_req     (dir_rx),
        .short_word (mode_r.short_word),
        .polarity   (mode_r.polarity),
        .phase      (mode_r.phase),
        .tick       (tick),
        .msb        (data_q[W-1]),
        .stat_rd    (stat_rd),
        .run        (run),
        .rot        (rot),
        .shin       (shin),
        .sclk       (sclk),
        .sd_o       (sd_o),
        .sd_oe      (sd_oe),
        .done       (done)
    );
endmodule

// File: rtl/hsm_master_chk.sv
`timescale 1ns/1ps
// hsm_master_chk: port-level properties of the serial master, bound to the top.
module hsm_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_we,
    input logic       data_we,
    input logic       dir_rx,
    input logic       stat_rd,
    input logic [7:0] mode_q,
    input logic [7:0] data_q,
    input logic       busy,
    input logic       done,
    input logic       irq,
    input logic       sclk,
    input logic       sd_o,
    input logic       sd_oe
);
    // R2: the line turns on low with the clock at its idle level.
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_oe) |-> (!sd_o && (sclk == mode_q[5])));

    // R3: a receive start never drives the line.
    assert_rx_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !busy && dir_rx) |=> !sd_oe);

    // R9: the line is released only after a high stop level, together with completion.
    assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_oe) |-> ($past(sd_o) && done));

    // R8: the clock rests at the polarity bit whenever no transfer runs.
    assert_idle_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && !done) |-> (sclk == mode_q[5]));

    // R10: the interrupt never stands without the completion flag.
    assert_irq_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);

    // R11: data writes while completion is pending leave the register alone.
    assert_data_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && data_we) |=> $stable(data_q));

    // R11: a status read clears the completion flag.
    assert_done_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && done) |=> !done);

    // R12: mode writes during an active transfer are dropped.
    assert_mode_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && mode_we) |=> $stable(mode_q));
endmodule

bind hsm_master hsm_master_chk u_hsm_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_we (mode_we),
    .data_we (data_we),
    .dir_rx  (dir_rx),
    .stat_rd (stat_rd),
    .mode_q  (mode_q),
    .data_q  (data_q),
    .busy    (busy),
    .done    (done),
    .irq     (irq),
    .sclk    (sclk),
    .sd_o    (sd_o),
    .sd_oe   (sd_oe)
);

// File: tb/hsm_master_bench.sv
`timescale 1ns/1ps
module hsm_master_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic       data_we = 1'b0;
    logic [7:0] data_wdata = '0;
    logic       dir_rx = 1'b0;
    logic       stat_rd = 1'b0;
    logic       sd_i = 1'b0;
    logic [7:0] mode_q;
    logic [7:0] data_q;
    logic       busy, done, irq, sclk, sd_o, sd_oe;

    always #10 clk = ~clk;

    hsm_master u_hsm_master (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .data_we(data_we), .data_wdata(data_wdata), .dir_rx(dir_rx),
        .stat_rd(stat_rd), .sd_i(sd_i), .mode_q(mode_q), .data_q(data_q),
        .busy(busy), .done(done), .irq(irq), .sclk(sclk), .sd_o(sd_o), .sd_oe(sd_oe)
    );

    // {mode, rx, data written, slave pattern, expected data register}
    localparam logic [32:0] VECS [8] = '{
        {8'h80, 1'b0, 8'hA5, 8'h00, 8'hA5},
        {8'hE4, 1'b0, 8'h3C, 8'h00, 8'h3C},
        {8'h98, 1'b0, 8'hB4, 8'h00, 8'h2D},
        {8'h40, 1'b1, 8'h00, 8'hC9, 8'hC9},
        {8'h3C, 1'b1, 8'hFF, 8'h15, 8'hD5},
        {8'hA0, 1'b0, 8'h01, 8'h00, 8'h01},
        {8'h64, 1'b1, 8'h5A, 8'h3E, 8'h3E},
        {8'hB0, 1'b0, 8'hFC, 8'h00, 8'h3F}
    };

    int total = 0;
    int bad   = 0;

    // Monitor state for the transfer in progress.
    logic       c_pol, c_pha, c_rx;
    logic [7:0] c_pat;
    int         c_n;
    int         m_cyc, m_start, m_oe, m_edges, m_idx;
    logic       m_prev, m_seen, m_last;
    logic [7:0] m_cap;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic [7:0] m);
        @(negedge clk); mode_we = 1'b1; mode_wdata = m;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic read_status();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    // One falling-edge observation of the serial lines.
    task mon_step();
        if (sd_oe) begin
            m_oe++;
            m_last = sd_o;
            if (!m_seen && !sd_o && sclk == c_pol) m_start++;
        end
        if (sclk != m_prev) begin
            m_seen = 1'b1;
            if (sclk == (c_pol ^ ~c_pha)) begin
                m_edges++;
                m_cap = {m_cap[6:0], sd_o};
                if (c_rx) begin
                    m_idx++;
                    if (m_idx < c_n) sd_i = c_pat[c_n-1-m_idx];
                end
            end
        end
        m_prev = sclk;
    endtask

    task automatic wait_done(input int limit);
        int k = 0;
        while (!done && k < limit) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic run_vec(input int vi);
        logic [32:0] v = VECS[vi];
        logic [7:0]  m = v[32:25];
        logic [7:0]  d = v[23:16];
        logic [7:0]  eq = v[7:0];
        int          h, t, exp_start, exp_bits;
        c_rx  = v[24];
        c_pat = v[15:8];
        c_pol = m[5];
        c_pha = m[6];
        c_n   = m[4] ? 6 : 8;
        h     = 1 << m[3:2];
        t     = c_rx ? 2 * c_n : 2 * c_n + 4;
        write_mode(m);
        chk(mode_q == m, "R12 idle mode write", int'(mode_q), int'(m));
        sd_i = c_rx ? c_pat[c_n-1] : 1'b0;
        @(negedge clk); data_we = 1'b1; data_wdata = d; dir_rx = c_rx;
        @(negedge clk); data_we = 1'b0;
        m_cyc = 0; m_start = 0; m_oe = 0; m_edges = 0; m_idx = 0;
        m_prev = c_pol; m_seen = 1'b0; m_last = 1'b0; m_cap = '0;
        mon_step();
        while (!done && m_cyc < 3000) begin
            @(posedge clk);
            m_cyc++;
            @(negedge clk);
            mon_step();
        end
        chk(m_cyc == t * h, "R7 transfer length", m_cyc, t * h);
        chk(data_q == eq, c_rx ? "R6 receive result" : "R5 rotate result", int'(data_q), int'(eq));
        chk(m_edges == c_n, "R4 sampling edges", m_edges, c_n);
        chk(irq == m[7], "R10 irq mask", int'(irq), int'(m[7]));
        chk(busy && done, "R10 done set", int'({busy, done}), 3);
        chk(sclk == c_pol, "R8 idle clock level", int'(sclk), int'(c_pol));
        if (c_rx) begin
            chk(m_oe == 0, "R3 receive line released", m_oe, 0);
        end else begin
            exp_start = 2 * h + ((!c_pha && !d[7]) ? h : 0);
            exp_bits  = int'(d) >> (8 - c_n);
            chk(m_start == exp_start, "R2 start bit width", m_start, exp_start);
            chk(int'(m_cap) % (1 << c_n) == exp_bits, "R5 bits MSB first",
                int'(m_cap) % (1 << c_n), exp_bits);
            chk(m_oe == t * h && m_last == 1'b1 && !sd_oe, "R9 stop and release",
                m_oe, t * h);
        end
        read_status();
        chk(!done && !busy && !irq, "R11 status read clears", int'({busy, done, irq}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(mode_q == 8'h00 && data_q == 8'h00, "R1 reset registers", int'({mode_q, data_q}), 0);
        chk(!busy && !done && !irq && !sclk && !sd_oe, "R1 reset outputs",
            int'({busy, done, irq, sclk, sd_oe}), 0);

        for (int i = 0; i < 8; i++) run_vec(i);

        // Writes during an active transfer (R11, R12).
        write_mode(8'h80);
        @(negedge clk); data_we = 1'b1; data_wdata = 8'hA5; dir_rx = 1'b0;
        @(negedge clk); data_we = 1'b0;
        repeat (5) @(negedge clk);
        data_we = 1'b1; data_wdata = 8'h00; mode_we = 1'b1; mode_wdata = 8'h00;
        @(negedge clk); data_we = 1'b0; mode_we = 1'b0;
        chk(mode_q == 8'h80, "R12 mode write blocked", int'(mode_q), 8'h80);
        wait_done(200);
        chk(data_q == 8'hA5, "R11 write while active ignored", int'(data_q), 8'hA5);

        // Write while completion pending is dropped (R11).
        @(negedge clk); data_we = 1'b1; data_wdata = 8'h11;
        @(negedge clk); data_we = 1'b0;
        repeat (3) @(negedge clk);
        chk(!sd_oe && done && busy, "R11 no start while done pending",
            int'({sd_oe, done, busy}), 3);
        chk(data_q == 8'hA5, "R11 write while done ignored", int'(data_q), 8'hA5);

        // After the status read a write starts again (R11).
        read_status();
        chk(!done && !busy, "R11 flag cleared", int'({done, busy}), 0);
        @(negedge clk); data_we = 1'b1; data_wdata = 8'h11;
        @(negedge clk); data_we = 1'b0;
        chk(data_q == 8'h11 && busy && sd_oe, "R11 restart after read",
            int'(data_q), 8'h11);
        wait_done(200);
        chk(done && data_q == 8'h11, "R5 restart result", int'(data_q), 8'h11);
        read_status();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule